// File: doc/BRIEF.md
# Arithmetic Status Flag Unit

This block is a 32-bit arithmetic and logic stage. It has two operand inputs and a three-bit operation code that selects add, subtract, bitwise AND, bitwise OR or bitwise XOR. The result leaves the block combinationally in the same cycle as the operands. Alongside it the block derives six status bits: carry, overflow, sign, zero, auxiliary carry and parity.

The status bits are kept in a register. It loads on a rising clock edge only while the flag-write enable is high, so a datapath can compute a value without disturbing flags that were set earlier. Subtraction is formed as the first operand plus the inverted second operand plus one. The carry and auxiliary-carry bits then report a borrow instead of a carry out. The logic operations clear the three arithmetic-only flags and still report sign, zero and parity of their result.

Top module: `flag_unit`

## Requirements
- R1: `result_o` gives a+b for code 0, a-b (modulo 2^32) for code 1, a AND b for code 2, a OR b for code 3 and a XOR b for code 4, in the same cycle as the inputs.
- R2: The carry flag (`flags_o[0]`) is set when code 0 produces a carry out of bit 31, or when code 1 needs a borrow (a < b as unsigned numbers).
- R3: The overflow flag (`flags_o[5]`) is set when the signed two's-complement result of code 0 or code 1 falls outside the 32-bit signed range.
- R4: The sign flag (`flags_o[4]`) equals bit 31 of the result.
- R5: The zero flag (`flags_o[3]`) is set exactly when all 32 result bits are zero.
- R6: The auxiliary flag (`flags_o[2]`) is set when code 0 carries out of bit 3 into bit 4, or when code 1 borrows into bit 3 from bit 4.
- R7: The parity flag (`flags_o[1]`) is set when result bits 7..0 contain an even number of ones. Higher bits have no effect on it.
- R8: For codes 2, 3 and 4 the carry, overflow and auxiliary flags are loaded as zero.
- R9: `flags_o` loads on a rising clock edge only when `flag_we_i` is high. With the enable low it holds its value whatever the operands and code are.
- R10: An active-low reset clears all six flags to zero.
- R11: Codes 5, 6 and 7 give a zero result. Their flags follow the logic rule, so only zero and parity are set (`flags_o` = 6'b001010).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| flag_we_i | input | 1 | Flag register load enable |
| result_o | output | 32 | Combinational result |
| flags_o | output | 6 | Registered flags {OF,SF,ZF,AF,PF,CF} |

## Verification
Additions are tried with operands that carry out of the nibble only, out of bit 31 only, across the signed boundary only, and with both carries together. This shows that each flag comes from its own carry point and not from a shared one. Subtractions mirror these cases: equal operands, zero minus one, the most negative value minus one, and a nibble borrow with no full borrow. These cases tell a borrow apart from an unsigned carry and catch an inverted polarity. The logic operations are run just after an addition that set carry, overflow and auxiliary. That shows they clear those flags and do not merely leave them alone. Hold, reserved-code and mid-stream reset cases separate the enable and reset paths from the data path.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;

  localparam int OP_W   = 3;
  localparam int FLAG_N = 6;

  localparam logic [OP_W-1:0] OP_ADD = 3'd0;
  localparam logic [OP_W-1:0] OP_SUB = 3'd1;
  localparam logic [OP_W-1:0] OP_AND = 3'd2;
  localparam logic [OP_W-1:0] OP_OR  = 3'd3;
  localparam logic [OP_W-1:0] OP_XOR = 3'd4;

  // flag bit positions in the packed status word
  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_AF = 2;
  localparam int FL_ZF = 3;
  localparam int FL_SF = 4;
  localparam int FL_OF = 5;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } status_t;

  function automatic logic op_is_arith(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic op_is_sub(input logic [OP_W-1:0] op);
    return op == OP_SUB;
  endfunction

  // carry into and out of the top bit disagree exactly on signed overflow
  function automatic logic signed_range_fault(input logic c_into_msb,
                                              input logic c_out_msb);
    return c_into_msb ^ c_out_msb;
  endfunction

endpackage

// File: rtl/flag_adder.sv
module flag_adder
  import flag_unit_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int NIB   = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_nib_o,
  output logic             c_msb_o,
  output logic             c_out_o,
  output logic             cry_o,
  output logic             aux_o,
  output logic             ovf_o
);
  localparam int MID = WIDTH - NIB - 1;

  logic [WIDTH-1:0] b_eff;
  logic [NIB:0]     low_part;
  logic [MID:0]     mid_part;
  logic [1:0]       top_part;

  assign b_eff = sub_i ? ~b_i : b_i;

  // three segments expose the nibble carry and the carry into the sign bit
  assign low_part = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]}
                  + {{NIB{1'b0}}, sub_i};
  assign c_nib_o  = low_part[NIB];

  assign mid_part = {1'b0, a_i[WIDTH-2:NIB]} + {1'b0, b_eff[WIDTH-2:NIB]}
                  + {{MID{1'b0}}, c_nib_o};
  assign c_msb_o  = mid_part[MID];

  assign top_part = {1'b0, a_i[WIDTH-1]} + {1'b0, b_eff[WIDTH-1]}
                  + {1'b0, c_msb_o};
  assign c_out_o  = top_part[1];

  assign sum_o = {top_part[0], mid_part[MID-1:0], low_part[NIB-1:0]};

  // on subtract a missing carry means a borrow
  assign cry_o = c_out_o ^ sub_i;
  assign aux_o = c_nib_o ^ sub_i;
  assign ovf_o = signed_range_fault(c_msb_o, c_out_o);

endmodule

// File: rtl/flag_bitwise.sv
module flag_bitwise
  import flag_unit_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/flag_eval.sv
module flag_eval #(
  parameter int WIDTH    = 32,
  parameter int PAR_BITS = 8
) (
  input  logic [WIDTH-1:0] res_i,
  output logic             sgn_o,
  output logic             zro_o,
  output logic             par_o
);
  logic [PAR_BITS-1:0] par_chain;

  assign sgn_o = res_i[WIDTH-1];
  assign zro_o = (res_i == '0);

  // running xor over the low bits; even count leaves the chain at zero
  genvar gi;
  generate
    for (gi = 0; gi < PAR_BITS; gi++) begin : g_par
      if (gi == 0) begin : g_first
        assign par_chain[gi] = res_i[gi];
      end else begin : g_next
        assign par_chain[gi] = par_chain[gi-1] ^ res_i[gi];
      end
    end
  endgenerate

  assign par_o = ~par_chain[PAR_BITS-1];
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_unit_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int NIB      = 4,
  parameter int PAR_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic              flag_we_i,
  output logic [WIDTH-1:0]  result_o,
  output logic [FLAG_N-1:0] flags_o
);
  logic             arith_sel;
  logic             sub_sel;
  logic [WIDTH-1:0] add_sum;
  logic [WIDTH-1:0] bit_res;
  logic             add_c_nib, add_c_msb, add_c_out;
  logic             add_cry, add_aux, add_ovf;
  logic             ev_sgn, ev_zro, ev_par;
  status_t          status_next;
  status_t          status_q;

  assign arith_sel = op_is_arith(op_i);
  assign sub_sel   = op_is_sub(op_i);

  flag_adder #(.WIDTH(WIDTH), .NIB(NIB)) u_add (
    .a_i     (a_i),
    .b_i     (b_i),
    .sub_i   (sub_sel),
    .sum_o   (add_sum),
    .c_nib_o (add_c_nib),
    .c_msb_o (add_c_msb),
    .c_out_o (add_c_out),
    .cry_o   (add_cry),
    .aux_o   (add_aux),
    .ovf_o   (add_ovf)
  );

  flag_bitwise #(.WIDTH(WIDTH)) u_bit (
    .op_i  (op_i),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (bit_res)
  );

  assign result_o = arith_sel ? add_sum : bit_res;

  flag_eval #(.WIDTH(WIDTH), .PAR_BITS(PAR_BITS)) u_eval (
    .res_i (result_o),
    .sgn_o (ev_sgn),
    .zro_o (ev_zro),
    .par_o (ev_par)
  );

  always_comb begin
    status_next.cry = arith_sel & add_cry;
    status_next.ovf = arith_sel & add_ovf;
    status_next.aux = arith_sel & add_aux;
    status_next.sgn = ev_sgn;
    status_next.zro = ev_zro;
    status_next.par = ev_par;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        status_q <= '0;
    else if (flag_we_i) status_q <= status_next;
  end

  assign flags_o = status_q;
endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk
  import flag_unit_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        op_i,
  input logic [WIDTH-1:0]  a_i,
  input logic [WIDTH-1:0]  b_i,
  input logic              flag_we_i,
  input logic [WIDTH-1:0]  result_o,
  input logic [FLAG_N-1:0] flags_o
);
  p_borrow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == OP_SUB) |=> flags_o[FL_CF] == ($past(a_i) < $past(b_i)));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_i == OP_ADD) |=> flags_o[FL_OF] ==
      (($past(a_i[WIDTH-1]) == $past(b_i[WIDTH-1])) &&
       ($past(result_o[WIDTH-1]) != $past(a_i[WIDTH-1]))));

  p_sign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o[FL_SF] == $past(result_o[WIDTH-1]));

  p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o[FL_ZF] == ($past(result_o) == '0));

  p_parity_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o[FL_PF] == ($countones($past(result_o[7:0])) % 2 == 0));

  p_logic_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)) |=>
      (flags_o[FL_CF] == 1'b0 && flags_o[FL_OF] == 1'b0 && flags_o[FL_AF] == 1'b0));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  p_reset_clear_r10: assert property (@(posedge clk_i)
    !rst_ni |=> flags_o == '0);

  p_reserved_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > OP_XOR) |-> result_o == '0);
endmodule

bind flag_unit flag_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .flag_we_i (flag_we_i),
  .result_o  (result_o),
  .flags_o   (flags_o)
);

// File: tb/flag_unit_bench.sv
`timescale 1ns/1ps
module flag_unit_bench;
  localparam int CLK_NS = 20;

  logic        clk;
  logic        rst_n;
  logic [2:0]  op;
  logic [31:0] a, b;
  logic        we;
  logic [31:0] result;
  logic [5:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [5:0] model_flags;

  flag_unit u_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b),
    .flag_we_i(we), .result_o(result), .flags_o(flags)
  );

  initial clk = 0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_result(input logic [2:0] o,
                                             input logic [31:0] x, input logic [31:0] y);
    case (o)
      3'd0: return x + y;
      3'd1: return x - y;
      3'd2: return x & y;
      3'd3: return x | y;
      3'd4: return x ^ y;
      default: return 32'h0;
    endcase
  endfunction

  // flags as {OF,SF,ZF,AF,PF,CF}
  function automatic logic [5:0] ref_flags(input logic [2:0] o,
                                           input logic [31:0] x, input logic [31:0] y);
    logic [32:0] wide;
    logic [31:0] r;
    logic cf, of, af, pf;
    r  = ref_result(o, x, y);
    cf = 0; of = 0; af = 0;
    if (o == 3'd0) begin
      wide = {1'b0, x} + {1'b0, y};
      cf = wide[32];
      of = (x[31] == y[31]) && (r[31] != x[31]);
      af = x[4] ^ y[4] ^ r[4];
    end else if (o == 3'd1) begin
      cf = x < y;
      of = (x[31] != y[31]) && (r[31] != x[31]);
      af = x[4] ^ y[4] ^ r[4];
    end
    pf = ($countones(r[7:0]) % 2) == 0;
    return {of, r[31], (r == 32'h0), af, pf, cf};
  endfunction

  task automatic apply(input logic [2:0] o, input logic [31:0] x,
                       input logic [31:0] y, input bit wr);
    logic [31:0] er;
    logic [5:0]  ef;
    @(negedge clk);
    op = o; a = x; b = y; we = wr;
    #2;
    er = ref_result(o, x, y);
    check(result == er, (o > 3'd4) ? "R11" : "R1", "result", result, er);
    if (wr) model_flags = ref_flags(o, x, y);
    @(posedge clk); #1;
    ef = model_flags;
    if (!wr) check(flags == ef, "R9", "held flags", {26'h0, flags}, {26'h0, ef});
    check(flags[0] == ef[0], "R2", "carry", {31'h0, flags[0]}, {31'h0, ef[0]});
    check(flags[5] == ef[5], "R3", "overflow", {31'h0, flags[5]}, {31'h0, ef[5]});
    check(flags[4] == ef[4], "R4", "sign", {31'h0, flags[4]}, {31'h0, ef[4]});
    check(flags[3] == ef[3], "R5", "zero", {31'h0, flags[3]}, {31'h0, ef[3]});
    check(flags[2] == ef[2], "R6", "aux", {31'h0, flags[2]}, {31'h0, ef[2]});
    check(flags[1] == ef[1], "R7", "parity", {31'h0, flags[1]}, {31'h0, ef[1]});
    if (wr && (o >= 3'd2))
      check(flags[0] == 0 && flags[5] == 0 && flags[2] == 0, "R8",
            "logic clears CF/OF/AF", {26'h0, flags}, {26'h0, ef & 6'b011010});
    we = 0;
  endtask

  task automatic t_reset_state();
    rst_n = 0; we = 0; op = 0; a = 0; b = 0;
    model_flags = 6'h0;
    repeat (2) @(posedge clk);
    #1 check(flags == 6'h0, "R10", "reset flags", {26'h0, flags}, 32'h0);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic t_add_cases();
    apply(3'd0, 32'h1, 32'h1, 1);
    apply(3'd0, 32'hFFFF_FFFF, 32'h1, 1);
    apply(3'd0, 32'h7FFF_FFFF, 32'h1, 1);
    apply(3'd0, 32'h0000_000F, 32'h1, 1);
    apply(3'd0, 32'h8000_0000, 32'h8000_0000, 1);
    apply(3'd0, 32'h0000_0100, 32'h0000_0200, 1);
    check(flags == 6'b000010, "R7", "parity ignores high bits", {26'h0, flags}, 32'b000010);
  endtask

  task automatic t_sub_cases();
    apply(3'd1, 32'h5, 32'h5, 1);
    apply(3'd1, 32'h0, 32'h1, 1);
    apply(3'd1, 32'h8000_0000, 32'h1, 1);
    apply(3'd1, 32'h10, 32'h1, 1);
    apply(3'd1, 32'h3, 32'h1, 1);
    apply(3'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1);
  endtask

  task automatic t_bitwise_cases();
    apply(3'd0, 32'h8000_000F, 32'h8000_0001, 1);
    apply(3'd2, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 1);
    apply(3'd0, 32'h8000_000F, 32'h8000_0001, 1);
    apply(3'd3, 32'h8000_0000, 32'h0000_0003, 1);
    apply(3'd0, 32'h8000_000F, 32'h8000_0001, 1);
    apply(3'd4, 32'h1234_5678, 32'h1234_5678, 1);
  endtask

  task automatic t_hold();
    apply(3'd0, 32'hFFFF_FFFF, 32'h1, 1);
    apply(3'd1, 32'h0, 32'h7, 0);
    apply(3'd2, 32'h0000_0001, 32'h0000_0003, 0);
  endtask

  task automatic t_reserved_ops();
    for (int c = 5; c < 8; c++) begin
      apply(3'(c), 32'hDEAD_BEEF, 32'h1357_9BDF, 1);
      check(flags == 6'b001010, "R11", "reserved flags", {26'h0, flags}, 32'b001010);
    end
  endtask

  task automatic t_reset_mid();
    apply(3'd0, 32'h7FFF_FFFF, 32'h1, 1);
    @(negedge clk) rst_n = 0;
    #2 check(flags == 6'h0, "R10", "async clear", {26'h0, flags}, 32'h0);
    model_flags = 6'h0;
    @(negedge clk) rst_n = 1;
  endtask

  initial begin
    t_reset_state();
    t_add_cases();
    t_sub_cases();
    t_bitwise_cases();
    t_hold();
    t_reserved_ops();
    t_reset_mid();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule